// File: doc/BRIEF.md
# Signed Nonrestoring Sequential Divider

This block divides a two's-complement dividend of twice the word width by a two's-complement divisor of one word width. It returns a one-word quotient and a one-word remainder. Software-style truncating division is the contract: the quotient rounds toward zero, and the remainder is zero or carries the dividend's sign. Internally the block produces one quotient digit per clock. Each step doubles the partial remainder and then either adds or subtracts the divisor, aligned to the upper half. The step never restores a previous value.

Each digit is +1 or -1. It comes from comparing the sign of the partial remainder with the sign of the divisor. After the last digit, one extra cycle does two things. It rewrites the digit string as a two's-complement number. It then applies at most one adjustment, of plus or minus one divisor, that moves the remainder onto the dividend's side of zero.

A caller pulses `start` while `busy` is low, then waits for the one-cycle `done` pulse. Operands whose quotient might not fit, and a zero divisor, are rejected at once with `divError`. The word width is the parameter `QW`, with a default of 8 and a minimum of 2.

Top module: `nrdiv_top`

## Requirements
- R1: For accepted operands, `quotient` is the dividend divided by the divisor with the result truncated toward zero. Examples: 5 / -3 gives -1 with remainder 2, and -5 / -3 gives 1 with remainder -2.
- R2: The remainder satisfies dividend = divisor * quotient + remainder. Its magnitude is below the divisor's magnitude, and it is either zero or has the dividend's sign, including at the extremes (16383 / -128 gives -127 rem 127 with QW = 8).
- R3: A zero divisor raises `divError`. In that case `done` is high in the cycle right after the accepting edge and `busy` stays low.
- R4: `divError` is raised whenever |dividend| >= |divisor| * 2^(QW-1). With QW = 8, 1280 / 10 is rejected and 1279 / 10 gives 127 rem 9.
- R5: For a valid operation, `busy` is high for exactly QW+1 cycles after the accepting edge. `done` is high for exactly one cycle, the cycle in which `busy` has just dropped, and `busy` and `done` are never high together.
- R6: A `start` that arrives while `busy` is high has no effect on the running operation, its timing or its results.
- R7: `quotient`, `remainder` and `divError` keep their values from the cycle of one `done` pulse until the next `done` pulse.
- R8: When the raw signed-digit result leaves the remainder on the wrong side of zero, a single adjustment fixes it. Example: 33 / -7 gives -4 rem 5.
- R9: An exact division whose raw remainder equals plus or minus the divisor is adjusted to a zero remainder. Examples: -4 / 2 gives -2 rem 0, and -16256 / -128 gives 127 rem 0.
- R10: While `rstN` is low, and in the first cycle after it rises, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request; accepted on a rising edge while `busy` is low |
| dividend | input | 2*QW | Two's-complement dividend |
| divisor | input | QW | Two's-complement divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | QW | Two's-complement quotient |
| remainder | output | QW | Two's-complement remainder |
| divError | output | 1 | Operands rejected (zero divisor or quotient range) |

## Verification
The bench keeps a behavioural reference model. It learns of each request at the same rising edge that the design samples it. It then predicts `busy` for the next QW+1 cycles and `done` at edge QW+1 after acceptance, or at the very next edge for a rejected request, and it works out the quotient and remainder with integer division. Every falling edge compares `busy`, `done`, the error flag and the held results with the model, so each output is checked in the exact cycle it is due and in every cycle it should hold. Directed operations additionally check literal expected values: the sign cases, the correction and exact-division cases, the range limit, a zero divisor, and a second request sent in the middle of a run.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

  // Strobes sent from the sequencer to the datapath, one cycle each.
  typedef struct packed {
    logic load;   // capture operands, seed partial remainder
    logic step;   // one shift-and-add/subtract iteration
    logic fix;    // convert digits, adjust once, register results
    logic fault;  // record a rejected request
  } nrdiv_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } nrdiv_state_t;

endpackage

// File: rtl/nrdiv_range.sv
// Rejects operands whose quotient might not fit a signed QW-bit word.
module nrdiv_range #(
  parameter int QW = 8
) (
  input  logic [2*QW-1:0] dividend,
  input  logic [QW-1:0]   divisor,
  output logic            outOfRange
);
  localparam int ZW = 2 * QW;

  logic [ZW-1:0] magZ;
  logic [QW-1:0] magD;
  logic [ZW-1:0] magZScaled;
  logic [ZW-1:0] magDWide;
  logic          divisorZero;

  // Negating the most negative value gives the right unsigned magnitude.
  assign magZ       = dividend[ZW-1] ? (~dividend + 1'b1) : dividend;
  assign magD       = divisor[QW-1]  ? (~divisor + 1'b1)  : divisor;
  assign magZScaled = magZ >> (QW - 1);
  assign magDWide   = {{(ZW-QW){1'b0}}, magD};
  assign divisorZero = (divisor == '0);

  assign outOfRange = divisorZero || (magZScaled >= magDWide);

endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          opError,
  output nrdiv_strobe_t strobe,
  output logic          busy,
  output logic          done
);
  localparam int CW = (QW > 2) ? $clog2(QW) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(QW - 1);

  nrdiv_state_t  state, stateNext;
  logic [CW-1:0] stepCnt, stepCntNext;
  logic          doneReg, doneNext;

  always_comb begin
    strobe      = '0;
    stateNext   = state;
    stepCntNext = stepCnt;
    doneNext    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (opError) begin
            strobe.fault = 1'b1;
            doneNext     = 1'b1;
          end else begin
            strobe.load = 1'b1;
            stateNext   = ST_RUN;
            stepCntNext = '0;
          end
        end
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        stepCntNext = stepCnt + 1'b1;
        if (stepCnt == LAST_STEP) stateNext = ST_FIX;
      end
      ST_FIX: begin
        strobe.fix = 1'b1;
        doneNext   = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneReg <= 1'b0;
    end else begin
      state   <= stateNext;
      stepCnt <= stepCntNext;
      doneReg <= doneNext;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneReg;

endmodule

// File: rtl/nrdiv_dpath.sv
module nrdiv_dpath
  import nrdiv_pkg::*;
#(
  parameter int QW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  nrdiv_strobe_t   strobe,
  input  logic [2*QW-1:0] dividend,
  input  logic [QW-1:0]   divisor,
  output logic            opError,
  output logic [QW-1:0]   quotient,
  output logic [QW-1:0]   remainder,
  output logic            divError
);
  localparam int ZW = 2 * QW;   // dividend width
  localparam int PW = ZW + 2;   // partial remainder, room for doubling
  localparam int RW = QW + 2;   // unscaled remainder before adjustment
  localparam int XW = QW + 1;   // quotient before adjustment

  logic [PW-1:0] partRem;
  logic [QW-1:0] divReg;
  logic [QW-1:0] digits;        // 1 means +1, 0 means -1
  logic          zNeg;
  logic [QW-1:0] quoReg, remReg;
  logic          errReg;

  nrdiv_range #(.QW(QW)) u_range (
    .dividend  (dividend),
    .divisor   (divisor),
    .outOfRange(opError)
  );

  // ---- one iteration ----
  logic [PW-1:0] divAligned;
  logic [PW-1:0] partShift;
  logic          signMatch;
  logic [PW-1:0] partNext;

  assign divAligned = {{(PW-ZW){divReg[QW-1]}}, divReg, {QW{1'b0}}};
  assign partShift  = {partRem[PW-2:0], 1'b0};
  assign signMatch  = (partRem[PW-1] == divReg[QW-1]);
  assign partNext   = signMatch ? (partShift - divAligned)
                                : (partShift + divAligned);

  // ---- conversion and single adjustment ----
  logic [RW-1:0] remRaw;
  logic [RW-1:0] divWide;
  logic [XW-1:0] quoRaw;
  logic          remNonZero, remWrongSide, remAtLimit, needAdjust;
  logic          remDivSame;
  logic [RW-1:0] remFinal;
  logic [XW-1:0] quoFinal;

  // Low QW bits of the final partial remainder are always zero.
  assign remRaw  = partRem[PW-1:QW];
  assign divWide = {{(RW-QW){divReg[QW-1]}}, divReg};
  // digit string d -> 2*d + 1 - 2^QW, kept one bit wide
  assign quoRaw  = {~digits[QW-1], digits[QW-2:0], 1'b1};

  assign remNonZero   = (remRaw != '0);
  assign remWrongSide = (remRaw[RW-1] != zNeg);
  assign remAtLimit   = (remRaw == divWide) || (remRaw == (~divWide + 1'b1));
  assign needAdjust   = remNonZero && (remWrongSide || remAtLimit);
  assign remDivSame   = (remRaw[RW-1] == divReg[QW-1]);

  always_comb begin
    remFinal = remRaw;
    quoFinal = quoRaw;
    if (needAdjust) begin
      if (remDivSame) begin
        remFinal = remRaw - divWide;
        quoFinal = quoRaw + {{(XW-1){1'b0}}, 1'b1};
      end else begin
        remFinal = remRaw + divWide;
        quoFinal = quoRaw - {{(XW-1){1'b0}}, 1'b1};
      end
    end
  end

  // ---- registers ----
  always_ff @(posedge clk) begin
    if (!rstN) begin
      partRem <= '0;
      divReg  <= '0;
      digits  <= '0;
      zNeg    <= 1'b0;
      quoReg  <= '0;
      remReg  <= '0;
      errReg  <= 1'b0;
    end else begin
      if (strobe.load) begin
        partRem <= {{(PW-ZW){dividend[ZW-1]}}, dividend};
        divReg  <= divisor;
        digits  <= '0;
        zNeg    <= dividend[ZW-1];
      end else if (strobe.step) begin
        partRem <= partNext;
        digits  <= {digits[QW-2:0], signMatch};
      end
      if (strobe.fix) begin
        quoReg <= quoFinal[QW-1:0];
        remReg <= remFinal[QW-1:0];
        errReg <= 1'b0;
      end else if (strobe.fault) begin
        errReg <= 1'b1;
      end
    end
  end

  assign quotient  = quoReg;
  assign remainder = remReg;
  assign divError  = errReg;

endmodule

// File: rtl/nrdiv_top.sv
module nrdiv_top
  import nrdiv_pkg::*;
#(
  parameter int QW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [2*QW-1:0] dividend,
  input  logic [QW-1:0]   divisor,
  output logic            busy,
  output logic            done,
  output logic [QW-1:0]   quotient,
  output logic [QW-1:0]   remainder,
  output logic            divError
);
  nrdiv_strobe_t strobe;
  logic          opError;

  nrdiv_ctrl #(.QW(QW)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opError(opError),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  nrdiv_dpath #(.QW(QW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dividend (dividend),
    .divisor  (divisor),
    .opError  (opError),
    .quotient (quotient),
    .remainder(remainder),
    .divError (divError)
  );

endmodule

// File: rtl/nrdiv_checker.sv
module nrdiv_checker #(
  parameter int QW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [2*QW-1:0] dividend,
  input logic [QW-1:0]   divisor,
  input logic            busy,
  input logic            done,
  input logic [QW-1:0]   quotient,
  input logic [QW-1:0]   remainder,
  input logic            divError
);
  localparam int EW = 2 * QW + 2;
  localparam int BW = $clog2(QW + 4);

  logic [2*QW-1:0] zCap;
  logic [QW-1:0]   dCap;
  logic [BW-1:0]   busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zCap    <= '0;
      dCap    <= '0;
      busyRun <= '0;
    end else begin
      if (start && !busy) begin
        zCap <= dividend;
        dCap <= divisor;
      end
      busyRun <= busy ? busyRun + 1'b1 : '0;
    end
  end

  logic signed [EW-1:0] rebuilt, zWide;
  logic [QW:0] magR, magD;
  assign rebuilt = $signed(dCap) * $signed(quotient) + $signed(remainder);
  assign zWide   = $signed(zCap);
  assign magR    = remainder[QW-1] ? ({1'b0, ~remainder} + 1'b1) : {1'b0, remainder};
  assign magD    = dCap[QW-1] ? ({1'b0, ~dCap} + 1'b1) : {1'b0, dCap};

  assert_identity_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && !divError) |-> (rebuilt == zWide));

  assert_rem_side_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && !divError) |-> ((remainder == '0) || (remainder[QW-1] == zCap[2*QW-1])));

  assert_rem_small_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && !divError) |-> (magR < magD));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == BW'(QW + 1)));

  assert_error_fast_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && divError) |-> !$past(busy));

  assert_results_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(divError)));

endmodule

bind nrdiv_top nrdiv_checker #(.QW(QW)) u_nrdivChecker (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .dividend (dividend),
  .divisor  (divisor),
  .busy     (busy),
  .done     (done),
  .quotient (quotient),
  .remainder(remainder),
  .divError (divError)
);

// File: tb/test_nrdiv_top.sv
`timescale 1ns/1ps
module test_nrdiv_top;
  localparam int QW = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [2*QW-1:0] dividendIn = '0;
  logic [QW-1:0]   divisorIn = '0;
  logic            busy, done, divError;
  logic [QW-1:0]   quotient, remainder;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  nrdiv_top #(.QW(QW)) i_nrdiv_top (
    .clk(clk), .rstN(rstN), .start(start),
    .dividend(dividendIn), .divisor(divisorIn),
    .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .divError(divError)
  );

  // ---------------- reference model ----------------
  function automatic bit refRejects(longint z, longint d);
    longint mz, md;
    mz = (z < 0) ? -z : z;
    md = (d < 0) ? -d : d;
    return (d == 0) || (mz >= md * (64'sd1 <<< (QW - 1)));
  endfunction

  logic   mBusy, mDone, mErr, haveRes;
  int     mLeft;
  longint pendQ, pendR, expQ, expR;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy <= 1'b0; mDone <= 1'b0; mErr <= 1'b0; haveRes <= 1'b0; mLeft <= 0;
    end else begin
      mDone <= 1'b0;
      if (mBusy) begin
        if (mLeft == 1) begin
          mBusy <= 1'b0; mDone <= 1'b1; mErr <= 1'b0;
          expQ <= pendQ; expR <= pendR; haveRes <= 1'b1;
        end
        mLeft <= mLeft - 1;
      end else if (start) begin
        longint z, d;
        z = longint'($signed(dividendIn));
        d = longint'($signed(divisorIn));
        if (refRejects(z, d)) begin
          mDone <= 1'b1; mErr <= 1'b1; haveRes <= 1'b0;
        end else begin
          mBusy <= 1'b1; mLeft <= QW + 1;
          pendQ <= z / d; pendR <= z % d;
        end
      end
    end
  end

  task automatic checkVal(string tag, longint actual, longint expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, actual, expected, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      checkVal("R5 busy", busy, mBusy);
      checkVal("R5 done", done, mDone);
      if (mDone) checkVal("R3/R4 divError", divError, mErr);
      if (haveRes) begin
        checkVal("R1/R7 quotient", longint'($signed(quotient)), expQ);
        checkVal("R2/R7 remainder", longint'($signed(remainder)), expR);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog R5: actual hung expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic runOp(longint z, longint d);
    @(negedge clk);
    dividendIn = (2*QW)'(z);
    divisorIn  = QW'(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!mDone) @(negedge clk);
  endtask

  task automatic expectOk(string tag, longint q, longint r);
    checkVal(tag, divError, 0);
    checkVal(tag, longint'($signed(quotient)), q);
    checkVal(tag, longint'($signed(remainder)), r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R10 busy in reset", busy, 0);
    checkVal("R10 done in reset", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R10 busy after reset", busy, 0);
    checkVal("R10 done after reset", done, 0);

    runOp(5, -3);       expectOk("R1 5/-3", -1, 2);
    runOp(-5, -3);      expectOk("R1 -5/-3", 1, -2);
    runOp(-5, 3);       expectOk("R2 -5/3", -1, -2);
    runOp(33, -7);      expectOk("R8 33/-7", -4, 5);
    runOp(-4, 2);       expectOk("R9 -4/2", -2, 0);
    runOp(-16256, -128); expectOk("R9 -16256/-128", 127, 0);
    runOp(16383, -128); expectOk("R2 16383/-128", -127, 127);
    runOp(0, 5);        expectOk("R2 0/5", 0, 0);
    runOp(1279, 10);    expectOk("R4 1279/10", 127, 9);
    runOp(-1279, -10);  expectOk("R4 -1279/-10", 127, -9);

    runOp(1280, 10);
    checkVal("R4 1280/10 rejected", divError, 1);
    runOp(7, 0);
    checkVal("R3 zero divisor flag", divError, 1);
    checkVal("R3 busy stays low", busy, 0);

    // R6: second request in the middle of a run
    @(negedge clk);
    dividendIn = 16'(33); divisorIn = 8'(-7); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    dividendIn = 16'(100); divisorIn = 8'(3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!mDone) @(negedge clk);
    checkVal("R6 done timing", done, 1);
    expectOk("R6 ignored start", -4, 5);

    // R7: hold after done
    repeat (4) @(negedge clk);
    expectOk("R7 hold", -4, 5);
    checkVal("R7 no extra done", done, 0);

    for (int i = 0; i < 400; i++) begin
      longint z, d;
      d = longint'($signed(8'($urandom)));
      if (i % 3 == 0) z = longint'($signed(16'($urandom)));
      else z = longint'($signed(12'($urandom)));
      runOp(z, d);
    end

    repeat (3) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule